// File: doc/BRIEF.md
# Gated ADSR Envelope Generator

This block shapes the loudness of one synthesizer voice over time. It produces an 8-bit envelope level that a later stage multiplies with the oscillator output. Raising the gate starts a linear climb to full scale. The level then falls to a programmable sustain level and stays there while the gate is held. Dropping the gate lets the level fall back to zero.

Two 8-bit rate words set the timing. The first word holds the attack and decay rate codes. The second holds the sustain level and the release rate code. Each 4-bit rate code selects a tick period from a 16-entry lookup scale. At a 1 MHz tick this scale covers a few milliseconds up to several seconds.

The falling segments run three times slower than attack for the same code. They are further slowed by a level-dependent divider, so decay and release trace an approximately exponential curve. Time advances only on cycles where the tick enable is high, so the block can run from a fast core clock.

Top module: `adsr_env_gen`

## Requirements
- R1: After reset the envelope level is 0 and the block is in the release phase, so it stays at 0 until the gate rises.
- R2: A rising gate enters attack. The level then increases by exactly 1 each time the attack period of code `rate_ad[7:4]` has elapsed in ticks. Periods are 9 ticks for code 0, 32 for code 1 and 63 for code 2.
- R3: When attack brings the level to 255, the block switches to decay. The level never wraps past 255.
- R4: In decay, the level decreases by 1 per step until it equals the sustain level, then holds. A decay step takes 3 × period(`rate_ad[3:0]`) × divider ticks.
- R5: The sustain level is `rate_sr[7:4]` copied into both nibbles (code × 17). Code 15 therefore sustains at full scale.
- R6: A falling gate enters release. The level decreases toward 0 with steps of 3 × period(`rate_sr[3:0]`) × divider ticks, and it never wraps below 0.
- R7: The falling-segment divider depends on the current level. It is 1 at level 93 or above, 2 for 54–92, 4 for 26–53, 8 for 14–25, 16 for 6–13 and 30 below 6.
- R8: A gate rise during release restarts the attack from the current level, not from zero.
- R9: Rate timing counts only cycles with `tick_en` high, and the level never changes on a cycle without a tick. Any gate change, ticked or not, restarts the step timing from zero and leaves the level unchanged on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Time-base enable, one pulse per envelope tick |
| gate | input | 1 | Note gate: high holds attack/decay/sustain, low releases |
| rate_ad | input | 8 | [7:4] attack rate code, [3:0] decay rate code |
| rate_sr | input | 8 | [7:4] sustain level code, [3:0] release rate code |
| env_level | output | 8 | Current envelope level |

## Verification
A gate change is registered on the first clock edge that sees it; that edge clears the step timers and leaves the level unchanged. The first level step lands exactly N ticked edges later, where N is the attack period or the falling period times the divider for the current level, and each later step follows after the same spacing recomputed for the new level. The bench predicts the level that each coming edge must produce before that edge, queues the prediction, and compares it one time unit after the edge, so every cycle of every phase is checked at the cycle it is due. Fixed-point checks at hand-computed edge counts cover the peak, the 93/92 divider boundary, the sustain plateau, retrigger from a non-zero level and throttled ticks.

// File: rtl/adsr_pkg.sv
package adsr_pkg;
  localparam int LVL_W     = 8;
  localparam int CODE_W    = 4;
  localparam int PER_W     = 17;
  localparam int DIV_W     = 5;
  localparam int FALL_MULT = 3;
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  typedef enum logic [1:0] {PH_ATTACK, PH_DECAY, PH_RELEASE} phase_t;

  // attack ticks per level step, indexed by rate code
  function automatic logic [PER_W-1:0] base_period(input logic [CODE_W-1:0] code);
    logic [PER_W-1:0] p;
    case (code)
      4'd0:  p = PER_W'(9);
      4'd1:  p = PER_W'(32);
      4'd2:  p = PER_W'(63);
      4'd3:  p = PER_W'(95);
      4'd4:  p = PER_W'(149);
      4'd5:  p = PER_W'(220);
      4'd6:  p = PER_W'(267);
      4'd7:  p = PER_W'(313);
      4'd8:  p = PER_W'(392);
      4'd9:  p = PER_W'(977);
      4'd10: p = PER_W'(1954);
      4'd11: p = PER_W'(3126);
      4'd12: p = PER_W'(3907);
      4'd13: p = PER_W'(11720);
      4'd14: p = PER_W'(19532);
      default: p = PER_W'(31251);
    endcase
    return p;
  endfunction

  function automatic logic [PER_W-1:0] fall_period(input logic [CODE_W-1:0] code);
    return base_period(code) * PER_W'(FALL_MULT);
  endfunction

  // level-dependent slow-down applied to falling segments
  function automatic logic [DIV_W-1:0] exp_div(input logic [LVL_W-1:0] lvl);
    logic [DIV_W-1:0] d;
    if (lvl >= LVL_W'(93))      d = DIV_W'(1);
    else if (lvl >= LVL_W'(54)) d = DIV_W'(2);
    else if (lvl >= LVL_W'(26)) d = DIV_W'(4);
    else if (lvl >= LVL_W'(14)) d = DIV_W'(8);
    else if (lvl >= LVL_W'(6))  d = DIV_W'(16);
    else                        d = DIV_W'(30);
    return d;
  endfunction

  function automatic logic [LVL_W-1:0] sus_expand(input logic [CODE_W-1:0] s);
    return {s, s};
  endfunction
endpackage

// File: rtl/adsr_rate_prescaler.sv
module adsr_rate_prescaler #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         clr,
  input  logic [W-1:0] period,
  output logic         rate_hit
);
  logic [W-1:0] cnt;

  assign rate_hit = tick_en && !clr && (cnt >= period - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (tick_en) cnt <= rate_hit ? '0 : cnt + W'(1);
  end

  // R9: counter never advances on an unticked cycle
  assert_cnt_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/adsr_exp_divider.sv
module adsr_exp_divider #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         rate_hit,
  input  logic [W-1:0] div,
  output logic         fall_step
);
  logic [W-1:0] cnt;

  assign fall_step = rate_hit && !clr && (cnt >= div - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (rate_hit) cnt <= fall_step ? '0 : cnt + W'(1);
  end

  // R7: divider position always stays inside the current divide ratio
  assert_cnt_below_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < div);
endmodule

// File: rtl/adsr_env_gen.sv
module adsr_env_gen
  import adsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       gate,
  input  logic [7:0] rate_ad,
  input  logic [7:0] rate_sr,
  output logic [7:0] env_level
);
  phase_t            phase;
  logic              gate_q;
  logic              gate_edge;
  logic              falling;
  logic [CODE_W-1:0] code_sel;
  logic [PER_W-1:0]  period;
  logic [DIV_W-1:0]  div;
  logic [LVL_W-1:0]  sus_lvl;
  logic              rate_hit;
  logic              fall_step;
  logic              step_evt;

  assign gate_edge = gate ^ gate_q;
  assign falling   = (phase != PH_ATTACK);
  assign sus_lvl   = sus_expand(rate_sr[7:4]);

  always_comb begin
    case (phase)
      PH_ATTACK: code_sel = rate_ad[7:4];
      PH_DECAY:  code_sel = rate_ad[3:0];
      default:   code_sel = rate_sr[3:0];
    endcase
  end

  assign period   = falling ? fall_period(code_sel) : base_period(code_sel);
  assign div      = exp_div(env_level);
  assign step_evt = falling ? fall_step : rate_hit;

  adsr_rate_prescaler #(.W(PER_W)) u_prescale (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clr(gate_edge),
    .period(period), .rate_hit(rate_hit)
  );

  adsr_exp_divider #(.W(DIV_W)) u_expdiv (
    .clk(clk), .rst_n(rst_n), .clr(gate_edge || !falling),
    .rate_hit(rate_hit), .div(div), .fall_step(fall_step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_RELEASE;
      gate_q    <= 1'b0;
      env_level <= '0;
    end else begin
      gate_q <= gate;
      if (gate_edge) begin
        phase <= gate ? PH_ATTACK : PH_RELEASE;
      end else if (step_evt) begin
        case (phase)
          PH_ATTACK: begin
            if (env_level != LVL_MAX) env_level <= env_level + LVL_W'(1);
            if (env_level >= LVL_MAX - LVL_W'(1)) phase <= PH_DECAY;
          end
          PH_DECAY:
            if (env_level > sus_lvl) env_level <= env_level - LVL_W'(1);
          default:
            if (env_level != '0) env_level <= env_level - LVL_W'(1);
        endcase
      end
    end
  end

  assert_attack_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ATTACK && step_evt && env_level != LVL_MAX) |=>
      env_level == $past(env_level) + LVL_W'(1));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (env_level == LVL_MAX) |=> env_level >= LVL_MAX - LVL_W'(1));

  assert_decay_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DECAY && env_level <= sus_lvl) |=> $stable(env_level));

  assert_release_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RELEASE && env_level == '0) |=> env_level == '0);

  assert_fall_enters_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_edge && !gate) |=> phase == PH_RELEASE);

  assert_edge_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gate_edge |=> $stable(env_level));

  assert_tick_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(env_level));
endmodule

// File: tb/adsr_env_gen_tb_top.sv
module adsr_env_gen_tb_top;
  localparam int CLK_P   = 10;
  localparam int MAX_CYC = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       gate = 1'b0;
  logic [7:0] rate_ad = 8'h00;
  logic [7:0] rate_sr = 8'h00;
  wire  [7:0] env_level;

  always #(CLK_P/2) clk = ~clk;

  adsr_env_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .rate_ad(rate_ad), .rate_sr(rate_sr), .env_level(env_level)
  );

  typedef struct { int lvl; string tag; } exp_t;
  exp_t  sb_q[$];
  int    checks = 0, errors = 0;
  string cur_tag = "R1";
  int    thr = 1, cyc = 0;
  bit    done = 1'b0;

  // reference state: 0 attack, 1 decay, 2 release
  int m_lvl = 0, m_st = 2, m_gq = 0, m_w = 0;

  function automatic int bm_period(int code);
    if (code == 1) return 32;
    if (code == 2) return 63;
    return 9;
  endfunction

  function automatic int bm_div(int lvl);
    if (lvl < 6)  return 30;
    if (lvl < 14) return 16;
    if (lvl < 26) return 8;
    if (lvl < 54) return 4;
    if (lvl < 93) return 2;
    return 1;
  endfunction

  task automatic check(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic model_cycle();
    int need;
    if (int'(gate) != m_gq) begin
      m_st = gate ? 0 : 2;
      m_w  = 0;
    end else if (tick_en) begin
      if (m_st == 0) need = bm_period(int'(rate_ad[7:4]));
      else need = 3 * bm_period(m_st == 1 ? int'(rate_ad[3:0]) : int'(rate_sr[3:0])) * bm_div(m_lvl);
      m_w++;
      if (m_w >= need) begin
        m_w = 0;
        if (m_st == 0) begin
          if (m_lvl < 255) m_lvl++;
          if (m_lvl == 255) m_st = 1;
        end else if (m_st == 1) begin
          if (m_lvl > int'(rate_sr[7:4]) * 17) m_lvl--;
        end else if (m_lvl > 0) m_lvl--;
      end
    end
    m_gq = int'(gate);
  endtask

  // driver: predicts the level due at the next edge, then waits for it
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = (thr == 1) || (cyc % thr == 0);
      cyc++;
      model_cycle();
      sb_q.push_back('{m_lvl, cur_tag});
      @(negedge clk);
    end
  endtask

  // monitor: compares each edge result against the queued prediction
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(e.tag, int'(env_level), e.lvl);
      end
    end
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(env_level), 0);
    rst_n = 1'b1;
    cur_tag = "R1";
    run(20);
    check("R1", int'(env_level), 0);

    // attack code 0, decay code 0, sustain 0xA (170), release code 0
    rate_ad = 8'h00; rate_sr = 8'hA0; gate = 1'b1; cur_tag = "R2";
    run(900);
    check("R2", int'(env_level), 99);   // steps at 9,18,..,891 after the edge
    cur_tag = "R3";
    run(1396);
    check("R3", int'(env_level), 255);  // peak reached on edge 2295
    cur_tag = "R4";
    run(2704);
    check("R5", int'(env_level), 170);

    // release from 170: 93 at +2079, 92 at +2106, 91 at +2160
    gate = 1'b0; cur_tag = "R7";
    run(2107);
    check("R7", int'(env_level), 92);
    run(53);
    check("R7", int'(env_level), 92);
    run(1);
    check("R7", int'(env_level), 91);
    cur_tag = "R6";
    run(20000);
    check("R6", int'(env_level), 0);

    // retrigger during release
    rate_ad = 8'h10; rate_sr = 8'h00; gate = 1'b1; cur_tag = "R8";
    run(1280);
    check("R2", int'(env_level), 39);
    gate = 1'b0;
    run(541);
    check("R6", int'(env_level), 34);
    gate = 1'b1;
    run(97);
    check("R8", int'(env_level), 37);
    gate = 1'b0;
    run(20000);
    check("R6", int'(env_level), 0);

    // throttled ticks: one tick in four cycles
    rate_ad = 8'h00; thr = 4; cyc = 0; gate = 1'b1; cur_tag = "R9";
    run(360);
    check("R9", int'(env_level), 9);

    // sustain code 15 holds at full scale
    thr = 1; rate_sr = 8'hF0; cur_tag = "R5";
    run(5000);
    check("R5", int'(env_level), 255);

    @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule